// File: doc/BRIEF.md
# Address-Matched Broadcast Neuron Element

This block is one processing element of a network whose neurons all sit on a single shared broadcast bus. At any moment one source neuron drives the bus with its address and its 9-bit output value; every element listens at the same time. Each element holds a content-addressed connection table of up to 64 entries. Each entry pairs the address of a source neuron with a signed 16-bit weight, so a neuron can be wired to any other neuron by address rather than by bus slot.

After accepting a broadcast, the element walks its table one entry per clock. Every valid entry whose address equals the broadcast address adds the product of the broadcast value and that entry's weight into a wide signed accumulator. While the walk runs, the element holds its bus-ready output low. A pass opens with a start pulse, which clears the accumulator. It closes with an end pulse, which turns the accumulator into the neuron's 9-bit output: an arithmetic right shift, then a clamp to 0..511. A one-cycle done pulse marks the end of the pass. The element drives its output value onto the bus only while the bus selects its own address and output enable is high.

Top module: `bcast_neuron`

## Requirements
- R1: After reset, bus_ready is 1 and pass_done is 0. The stored output value is 0, so drv_val is 0 even while the element is selected. drv_en is 0 while out_en is 0.
- R2: A table write with tbl_we high stores tbl_valid, tbl_src and tbl_weight at index tbl_idx. An entry whose valid bit is 0 never contributes, whatever its address.
- R3: A broadcast is accepted when bus_valid and bus_ready are high inside an open pass. bus_ready is then 0 for exactly 64 clock cycles (one per table entry), starting with the cycle after acceptance.
- R4: For each accepted broadcast, every valid entry whose address equals bus_src adds bus_val (unsigned) times its weight (signed two's complement) to the accumulator. Duplicate entries for one address each contribute.
- R5: pass_start, when bus_ready is high, opens a pass and clears the accumulator. This holds even when a pass is already open.
- R6: pass_end, when bus_ready is high in an open pass, closes the pass. One cycle later, pass_done is 1 for exactly one cycle and the output value equals the accumulator shifted right arithmetically by 8, clamped to 0 when negative and to 511 when above 511.
- R7: drv_en is 1 exactly when out_en is 1 and sel_addr equals my_addr. drv_val equals the stored output value while drv_en is 1 and is 0 otherwise.
- R8: When no pass is open, bus_valid and pass_end are ignored: bus_ready stays 1 and pass_done stays 0.
- R9: While bus_ready is 0, pass_end and pass_start are ignored. No done pulse follows, and the accumulator keeps its running sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| my_addr | input | 10 | This element's own neuron address |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 6 | Table entry index to write |
| tbl_valid | input | 1 | Valid bit for the written entry |
| tbl_src | input | 10 | Source address for the written entry |
| tbl_weight | input | 16 | Signed weight for the written entry |
| pass_start | input | 1 | Opens a pass and clears the accumulator |
| pass_end | input | 1 | Closes the pass and computes the output |
| pass_done | output | 1 | One-cycle pulse after a pass closes |
| bus_valid | input | 1 | Broadcast present on the bus |
| bus_src | input | 10 | Address of the broadcasting neuron |
| bus_val | input | 9 | Value of the broadcasting neuron |
| bus_ready | output | 1 | Element can accept a broadcast or control pulse |
| sel_addr | input | 10 | Address currently selected to drive the bus |
| out_en | input | 1 | Output enable for bus driving |
| drv_en | output | 1 | This element drives the bus |
| drv_val | output | 9 | Output value driven to the bus |

## Verification
A wrong table entry, a missed match or a sign error in the products cannot be seen until the pass closes. It then shows up in drv_val in the cycle after pass_end, either as a clamped value at the wrong end of the range or as an offset sum. The bench therefore closes many short passes with few broadcasts each, so that a fault lands close to the cycle that caused it. A walk that runs one entry too long or too short shows at once, as a bus_ready low count other than 64 on the very next broadcast. A control pulse wrongly taken during a walk shows as an unexpected pass_done one cycle later.

// File: rtl/nrn_pkg.sv
// Shared types for the broadcast neuron element.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package nrn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no pass open
        ST_WAIT = 2'd1,   // pass open, waiting for a broadcast or control
        ST_SCAN = 2'd2    // walking the connection table
    } nrn_state_t;
endpackage

// File: rtl/nrn_syn_table.sv
// Connection table: DEPTH entries of (valid, source address, weight).
// One write port, one combinational read port used by the sequential walk.
// Assumes: writes and reads of the same entry in one cycle read the old value.
module nrn_syn_table #(
    parameter int DEPTH    = 64,
    parameter int ADDR_W   = 10,
    parameter int WEIGHT_W = 16,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_valid,
    input  logic [ADDR_W-1:0]   wr_src,
    input  logic [WEIGHT_W-1:0] wr_weight,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic                rd_valid,
    output logic [ADDR_W-1:0]   rd_src,
    output logic [WEIGHT_W-1:0] rd_weight
);
    logic [DEPTH-1:0]    valid_q;
    logic [ADDR_W-1:0]   src_q [DEPTH];
    logic [WEIGHT_W-1:0] wt_q  [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        // Entry valid bit: cleared by reset, set or cleared by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid_q[e] <= 1'b0;
            else if (sel)
                valid_q[e] <= wr_valid;
        end

        // Entry payload: address and weight, loaded on write only.
        always_ff @(posedge clk) begin
            if (sel) begin
                src_q[e] <= wr_src;
                wt_q[e]  <= wr_weight;
            end
        end
    end

    // Read port for the walk.
    assign rd_valid  = valid_q[rd_idx];
    assign rd_src    = src_q[rd_idx];
    assign rd_weight = wt_q[rd_idx];
endmodule

// File: rtl/nrn_walk_ctrl.sv
// Pass and walk controller. Accepts broadcasts, steps the table index one
// entry per cycle, flags matching entries and issues clear/finish strobes.
// Assumes: control pulses are single-cycle; priority start > end > broadcast.
module nrn_walk_ctrl
    import nrn_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 10,
    parameter int VAL_W  = 9,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pass_start,
    input  logic              pass_end,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_src,
    input  logic [VAL_W-1:0]  bus_val,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_src,
    output logic [IDX_W-1:0]  walk_idx,
    output logic              hit,
    output logic [VAL_W-1:0]  hit_val,
    output logic              acc_clr,
    output logic              fin,
    output logic              bus_ready,
    output logic              done
);
    nrn_state_t        state_q;
    logic [ADDR_W-1:0] src_q;
    logic [VAL_W-1:0]  val_q;
    logic [IDX_W-1:0]  idx_q;
    logic              done_q;
    logic              accept;
    logic              last;

    // Decode of control strobes from the current state.
    always_comb begin
        bus_ready = (state_q != ST_SCAN);
        acc_clr   = bus_ready && pass_start;
        fin       = (state_q == ST_WAIT) && !pass_start && pass_end;
        accept    = (state_q == ST_WAIT) && !pass_start && !pass_end && bus_valid;
        last      = (idx_q == IDX_W'(DEPTH - 1));
    end

    // State register: opens, walks and closes passes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (acc_clr)
            state_q <= ST_WAIT;
        else if (fin)
            state_q <= ST_IDLE;
        else if (accept)
            state_q <= ST_SCAN;
        else if (state_q == ST_SCAN && last)
            state_q <= ST_WAIT;
    end

    // Walk index: restarts on acceptance, steps during the walk.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (accept)
            idx_q <= '0;
        else if (state_q == ST_SCAN)
            idx_q <= idx_q + 1'b1;
    end

    // Latch of the accepted broadcast for the duration of the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            val_q <= '0;
        end else if (accept) begin
            src_q <= bus_src;
            val_q <= bus_val;
        end
    end

    // Done pulse one cycle after the pass closes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= fin;
    end

    assign walk_idx = idx_q;
    assign hit      = (state_q == ST_SCAN) && rd_valid && (rd_src == src_q);
    assign hit_val  = val_q;
    assign done     = done_q;

    // R3: an accepted broadcast drops ready on the next cycle.
    a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !bus_ready);
    // R3: the walk ends after the last entry and ready returns.
    a_r3_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && last) |=> bus_ready);
    // R6: done is a single-cycle pulse.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/nrn_mac.sv
// Multiply-accumulate: unsigned broadcast value times signed weight,
// sign-extended into a wide signed accumulator.
// Assumes: clear and hit never coincide (clear only when not walking).
module nrn_mac #(
    parameter int VAL_W    = 9,
    parameter int WEIGHT_W = 16,
    parameter int ACC_W    = 40,
    localparam int PROD_W  = VAL_W + 1 + WEIGHT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    hit,
    input  logic [VAL_W-1:0]        val,
    input  logic [WEIGHT_W-1:0]     weight,
    output logic signed [ACC_W-1:0] acc
);
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic signed [ACC_W-1:0]  acc_q;

    assign prod     = $signed({1'b0, val}) * $signed(weight);
    assign prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};

    // Accumulator: cleared at pass start, adds each matching product.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (clr)
            acc_q <= '0;
        else if (hit)
            acc_q <= acc_q + prod_ext;
    end

    assign acc = acc_q;

    // R5: a clear leaves a zero accumulator.
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));
    // R4: without a match or clear the sum holds.
    a_r4_hold_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !hit) |=> $stable(acc));
endmodule

// File: rtl/nrn_activation.sv
// Output stage: arithmetic shift of the accumulator, clamp to 0..2^VAL_W-1,
// registered when the pass finishes.
// Assumes: SHIFT < ACC_W - VAL_W.
module nrn_activation #(
    parameter int ACC_W = 40,
    parameter int VAL_W = 9,
    parameter int SHIFT = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fin,
    input  logic signed [ACC_W-1:0] acc,
    output logic [VAL_W-1:0]        out_val
);
    logic signed [ACC_W-1:0] shifted;
    logic [VAL_W-1:0]        clamped;
    logic [VAL_W-1:0]        out_q;

    // Clamp of the shifted sum into the unsigned output range.
    always_comb begin
        shifted = acc >>> SHIFT;
        if (shifted[ACC_W-1])
            clamped = '0;
        else if (|shifted[ACC_W-2:VAL_W])
            clamped = '1;
        else
            clamped = shifted[VAL_W-1:0];
    end

    // Output register: loaded once per pass.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (fin)
            out_q <= clamped;
    end

    assign out_val = out_q;

    // R6: a negative sum yields a zero output.
    a_r6_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && acc[ACC_W-1]) |=> (out_val == '0));
    // R6: output only changes when a pass finishes.
    a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(out_val));
endmodule

// File: rtl/bcast_neuron.sv
// Broadcast-bus neuron element. Ties the connection table, walk controller,
// multiply-accumulate and output stage together, and drives the bus when
// its own address is selected.
// Assumes: one broadcaster at a time; table is loaded outside of passes.
module bcast_neuron #(
    parameter int DEPTH    = 64,
    parameter int ADDR_W   = 10,
    parameter int WEIGHT_W = 16,
    parameter int VAL_W    = 9,
    parameter int ACC_W    = 40,
    parameter int SHIFT    = 8,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   my_addr,
    input  logic                tbl_we,
    input  logic [IDX_W-1:0]    tbl_idx,
    input  logic                tbl_valid,
    input  logic [ADDR_W-1:0]   tbl_src,
    input  logic [WEIGHT_W-1:0] tbl_weight,
    input  logic                pass_start,
    input  logic                pass_end,
    output logic                pass_done,
    input  logic                bus_valid,
    input  logic [ADDR_W-1:0]   bus_src,
    input  logic [VAL_W-1:0]    bus_val,
    output logic                bus_ready,
    input  logic [ADDR_W-1:0]   sel_addr,
    input  logic                out_en,
    output logic                drv_en,
    output logic [VAL_W-1:0]    drv_val
);
    logic [IDX_W-1:0]        walk_idx;
    logic                    rd_valid;
    logic [ADDR_W-1:0]       rd_src;
    logic [WEIGHT_W-1:0]     rd_weight;
    logic                    hit;
    logic [VAL_W-1:0]        hit_val;
    logic                    acc_clr;
    logic                    fin;
    logic signed [ACC_W-1:0] acc;
    logic [VAL_W-1:0]        out_val;

    nrn_syn_table #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .WEIGHT_W(WEIGHT_W)
    ) table_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_valid(tbl_valid),
        .wr_src(tbl_src), .wr_weight(tbl_weight),
        .rd_idx(walk_idx), .rd_valid(rd_valid), .rd_src(rd_src),
        .rd_weight(rd_weight)
    );

    nrn_walk_ctrl #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .VAL_W(VAL_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .pass_start(pass_start), .pass_end(pass_end),
        .bus_valid(bus_valid), .bus_src(bus_src), .bus_val(bus_val),
        .rd_valid(rd_valid), .rd_src(rd_src),
        .walk_idx(walk_idx), .hit(hit), .hit_val(hit_val),
        .acc_clr(acc_clr), .fin(fin), .bus_ready(bus_ready),
        .done(pass_done)
    );

    nrn_mac #(
        .VAL_W(VAL_W), .WEIGHT_W(WEIGHT_W), .ACC_W(ACC_W)
    ) mac_i (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .hit(hit),
        .val(hit_val), .weight(rd_weight), .acc(acc)
    );

    nrn_activation #(
        .ACC_W(ACC_W), .VAL_W(VAL_W), .SHIFT(SHIFT)
    ) act_i (
        .clk(clk), .rst_n(rst_n), .fin(fin), .acc(acc), .out_val(out_val)
    );

    // Bus driver: only when this element's address is selected and enabled.
    always_comb begin
        drv_en  = out_en && (sel_addr == my_addr);
        drv_val = drv_en ? out_val : '0;
    end

    // R7: never drive without enable and own-address selection.
    a_r7_drive_guard: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (out_en && sel_addr == my_addr));
    // R9: a control pulse during a walk yields no done pulse.
    a_r9_no_done_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |=> !pass_done);
endmodule

// File: tb/bcast_neuron_tb_top.sv
`timescale 1ns/1ps
module bcast_neuron_tb_top;
    localparam int DEPTH = 64;
    localparam int SHIFT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  my_addr = 10'd5;
    logic        tbl_we = 1'b0;
    logic [5:0]  tbl_idx = '0;
    logic        tbl_valid = 1'b0;
    logic [9:0]  tbl_src = '0;
    logic [15:0] tbl_weight = '0;
    logic        pass_start = 1'b0;
    logic        pass_end = 1'b0;
    logic        pass_done;
    logic        bus_valid = 1'b0;
    logic [9:0]  bus_src = '0;
    logic [8:0]  bus_val = '0;
    logic        bus_ready;
    logic [9:0]  sel_addr = '0;
    logic        out_en = 1'b0;
    logic        drv_en;
    logic [8:0]  drv_val;

    always #4 clk = ~clk;

    bcast_neuron dut_i (
        .clk(clk), .rst_n(rst_n), .my_addr(my_addr),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid),
        .tbl_src(tbl_src), .tbl_weight(tbl_weight),
        .pass_start(pass_start), .pass_end(pass_end), .pass_done(pass_done),
        .bus_valid(bus_valid), .bus_src(bus_src), .bus_val(bus_val),
        .bus_ready(bus_ready), .sel_addr(sel_addr), .out_en(out_en),
        .drv_en(drv_en), .drv_val(drv_val)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Bench model of the table and pass.
    bit          m_valid [DEPTH];
    logic [9:0]  m_src   [DEPTH];
    logic [15:0] m_wt    [DEPTH];
    longint      m_acc = 0;
    bit          m_open = 0;
    int          m_out = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint match_sum(input logic [9:0] src, input int val);
        longint s = 0;
        for (int e = 0; e < DEPTH; e++)
            if (m_valid[e] && m_src[e] == src)
                s += longint'(val) * longint'($signed(m_wt[e]));
        return s;
    endfunction

    function automatic int clamp_out(input longint a);
        longint sh = a >>> SHIFT;
        if (sh < 0) return 0;
        if (sh > 511) return 511;
        return int'(sh);
    endfunction

    task automatic wr_entry(input int idx, input bit v, input int src, input int w);
        @(negedge clk);
        tbl_we = 1; tbl_idx = 6'(idx); tbl_valid = v;
        tbl_src = 10'(src); tbl_weight = 16'(w);
        @(negedge clk);
        tbl_we = 0;
        m_valid[idx] = v; m_src[idx] = 10'(src); m_wt[idx] = 16'(w);
    endtask

    task automatic do_start();
        @(negedge clk);
        pass_start = 1;
        @(negedge clk);
        pass_start = 0;
        m_acc = 0; m_open = 1;
    endtask

    // Broadcast one value; checks the ready-low window length (R3).
    task automatic do_bcast(input int src, input int val);
        int cnt = 0;
        @(negedge clk);
        bus_valid = 1; bus_src = 10'(src); bus_val = 9'(val);
        @(negedge clk);
        bus_valid = 0;
        while (!bus_ready && cnt < 200) begin
            cnt++;
            @(negedge clk);
        end
        if (m_open) begin
            chk("R3 ready-low cycles", cnt, DEPTH);
            m_acc += match_sum(10'(src), val);
        end else begin
            chk("R8 broadcast ignored outside pass", cnt, 0);
        end
    endtask

    // Close the pass and check done pulse and driven output (R6, R4).
    task automatic do_end(input string req);
        @(negedge clk);
        pass_end = 1;
        sel_addr = my_addr; out_en = 1;
        @(negedge clk);
        pass_end = 0;
        if (m_open) begin
            m_out = clamp_out(m_acc);
            chk("R6 done pulse", pass_done, 1);
            chk(req, drv_val, m_out);
            m_open = 0;
        end else begin
            chk("R8 end ignored outside pass", pass_done, 0);
        end
        @(negedge clk);
        chk("R6 done single cycle", pass_done, 0);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int e = 0; e < DEPTH; e++) begin
            m_valid[e] = 0; m_src[e] = '0; m_wt[e] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state.
        chk("R1 ready after reset", bus_ready, 1);
        chk("R1 done after reset", pass_done, 0);
        chk("R1 drv_en off", drv_en, 0);
        sel_addr = my_addr; out_en = 1;
        #1;
        chk("R1 output zero", drv_val, 0);
        out_en = 0;

        // Table: duplicates for address 3, an invalid entry (R2), random rest.
        wr_entry(0, 1, 3, 100);
        wr_entry(1, 1, 3, 50);
        wr_entry(2, 0, 3, 1000);
        wr_entry(62, 1, 21, 32767);
        wr_entry(63, 1, 20, -32768);
        for (int e = 3; e < 62; e++)
            wr_entry(e, ($urandom % 4) != 0, 4 + ($urandom % 4),
                     int'($urandom % 1200) - 600);

        // R4/R2: duplicates sum, invalid entry skipped: (100+50)*200>>8 = 117.
        do_start();
        do_bcast(3, 200);
        do_end("R4 R2 duplicate sum without invalid entry");
        chk("R2 directed value", m_out, 117);

        // R6: saturation high and low.
        do_start();
        do_bcast(21, 511);
        do_end("R6 clamp to 511");
        do_start();
        do_bcast(20, 511);
        do_end("R6 clamp negative to 0");

        // R8: broadcast and end with no open pass.
        do_bcast(3, 100);
        do_end("R8 unused");

        // R5: second start clears earlier sum.
        do_start();
        do_bcast(21, 400);
        do_start();
        do_bcast(3, 10);
        do_end("R5 restart clears accumulator");

        // R9: end and start pulsed mid-walk are ignored.
        do_start();
        @(negedge clk);
        bus_valid = 1; bus_src = 10'd3; bus_val = 9'd300;
        @(negedge clk);
        bus_valid = 0;
        repeat (5) @(negedge clk);
        pass_end = 1;
        @(negedge clk);
        pass_end = 0;
        chk("R9 no done during walk", pass_done, 0);
        pass_start = 1;
        @(negedge clk);
        pass_start = 0;
        while (!bus_ready) @(negedge clk);
        m_acc += match_sum(10'd3, 300);
        do_end("R9 sum kept through ignored pulses");

        // Random passes (R4, R6).
        for (int p = 0; p < 24; p++) begin
            int nb = 1 + ($urandom % 5);
            do_start();
            for (int b = 0; b < nb; b++)
                do_bcast(3 + ($urandom % 6), $urandom % 512);
            do_end("R4 random pass output");
        end

        // R7: drive only on own address with enable.
        for (int k = 0; k < 20; k++) begin
            bit en_exp;
            @(negedge clk);
            sel_addr = ($urandom % 2) ? my_addr : 10'($urandom % 16);
            out_en = $urandom % 2;
            #1;
            en_exp = out_en && (sel_addr == my_addr);
            chk("R7 drive enable", drv_en, en_exp);
            chk("R7 drive value", drv_val, en_exp ? m_out : 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule